// File: doc/BRIEF.md
# Direct-Mapped Write-Back Cache with Critical-Word-First Refill

This block is a direct-mapped data cache placed between a processor load/store port and a slower memory port. Addresses are word addresses. Each line holds several consecutive words. The line index is the block address taken modulo the line count, and each line keeps a tag, a valid bit, a dirty bit and its words. A request completes in the same cycle it is presented when the line is valid and its tag matches.

A store that hits changes only the cached copy and marks the line dirty. When a miss lands on a dirty line, the whole victim line goes back to memory, offset 0 first, before any refill beat is issued. The refill starts at the requested word and wraps around the line. A read miss completes on the first refill beat, with that beat's data, so the processor restarts while the rest of the line is still arriving.

While a fill is in progress, a read of a word of that line that has already arrived completes at once. Every other request waits until the fill is done. A store miss allocates the line: the refill completes first, and then the held store hits and marks the line dirty. Each memory beat is paced by a valid/ready handshake.

Top module: `dm_cwf_cache`

## Requirements
- R1: A request to a valid line whose stored tag equals the address tag completes in the cycle it is presented while no memory transfer is active, and a read returns the stored word. Index = address[OFF+IDX-1:OFF], offset = address[OFF-1:0], tag = the remaining upper bits, where OFF = log2(WORDS) and IDX = log2(LINES).
- R2: Reset clears all valid and dirty bits. After reset no memory beat is active, and the first access misses without any write-back.
- R3: With 16 lines of 4 words, the reads 0, 16, 32, 0, 16, 32, 64, 64, 0 give miss, miss, miss, hit, hit, hit, miss, hit, miss, which is 5 misses. This is the same pattern that 256 single-word lines give for 0, 16, 32, 0, 16, 32, 256, 256, 0.
- R4: Refill reads run at offsets k, k+1, ... modulo WORDS, where k is the requested offset, and end at k-1.
- R5: A read miss completes in the cycle of the first refill beat, and cpu_rdata equals that beat's mem_rdata.
- R6: During a fill, a read of an already-arrived word of the filling line completes at once. A store, or a read of a word that has not yet arrived, waits until the fill ends.
- R7: A store hit completes with no memory beat and leaves memory unchanged.
- R8: A miss on a dirty line first writes all WORDS words of the old line (mem_we=1), offset 0 upward, with their cached data. The refill reads follow.
- R9: A miss on a clean or invalid line issues no write beat.
- R10: A store miss refills the line and then writes the store data. The line becomes dirty, so its later eviction writes the store data back.
- R11: While mem_valid is high and mem_ready is low, mem_valid, mem_we, mem_addr and mem_wdata hold until the beat is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Processor request, held until cpu_ready |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | ADDR_W | Word address |
| cpu_wdata | input | DATA_W | Store data |
| cpu_ready | output | 1 | Request completes this cycle |
| cpu_rdata | output | DATA_W | Load data, valid with cpu_ready |
| mem_valid | output | 1 | Memory beat requested |
| mem_we | output | 1 | 1 = write-back beat, 0 = refill beat |
| mem_addr | output | ADDR_W | Beat word address |
| mem_wdata | output | DATA_W | Write-back data |
| mem_ready | input | 1 | Beat accepted this cycle |
| mem_rdata | input | DATA_W | Refill data, valid when a read beat is accepted |

## Verification
Several rules are checked by the assertions on every cycle. These are the handshake hold, the wrap-by-one offset step between consecutive refill beats, the write-back starting at offset 0 and stepping upward into the refill, stores completing only while memory is idle, and only reads completing during a fill. Other behaviours can only be shown by the bench's directed scenarios, checked against its behavioural model: the scaled hit/miss sequence, early restart on the exact critical beat, the in-fill hit versus stall distinction, write-allocate merging, and write-back data reaching memory.

// File: rtl/dm_cwf_cache.sv
`timescale 1ns/1ps
module dm_cwf_cache #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 32,
  parameter int LINES  = 16,
  parameter int WORDS  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_ready,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              mem_valid,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ready,
  input  logic [DATA_W-1:0] mem_rdata
);
  localparam int OFF_W = $clog2(WORDS);
  localparam int IDX_W = $clog2(LINES);
  localparam int TAG_W = ADDR_W - IDX_W - OFF_W;

  typedef enum logic [1:0] {S_IDLE, S_WB, S_FILL} st_t;
  st_t st;

  logic [DATA_W-1:0] data_q [LINES*WORDS];
  logic [TAG_W-1:0]  tag_q  [LINES];
  logic [LINES-1:0]  valid_q, dirty_q;
  logic [WORDS-1:0]  got_q;
  logic [ADDR_W-1:0] miss_q;
  logic              miss_we_q;
  logic [OFF_W-1:0]  cnt_q;

  wire [TAG_W-1:0] c_tag = cpu_addr[ADDR_W-1 -: TAG_W];
  wire [IDX_W-1:0] c_idx = cpu_addr[OFF_W +: IDX_W];
  wire [OFF_W-1:0] c_off = cpu_addr[OFF_W-1:0];
  wire [TAG_W-1:0] m_tag = miss_q[ADDR_W-1 -: TAG_W];
  wire [IDX_W-1:0] m_idx = miss_q[OFF_W +: IDX_W];
  wire [OFF_W-1:0] m_off = miss_q[OFF_W-1:0];
  wire [OFF_W-1:0] fill_off = m_off + cnt_q;

  wire beat     = mem_valid && mem_ready;
  wire last     = cnt_q == OFF_W'(WORDS-1);
  wire tag_hit  = valid_q[c_idx] && tag_q[c_idx] == c_tag;
  wire fill_hit = st == S_FILL && !cpu_we && c_idx == m_idx && c_tag == m_tag && got_q[c_off];
  wire crit     = st == S_FILL && cnt_q == '0 && beat && !miss_we_q;
  wire hit_wr   = st == S_IDLE && cpu_req && cpu_we && tag_hit;
  wire fill_wr  = st == S_FILL && beat;

  assign cpu_ready = (st == S_IDLE && cpu_req && tag_hit) || (cpu_req && fill_hit) || crit;
  assign cpu_rdata = crit ? mem_rdata : data_q[{c_idx, c_off}];
  assign mem_valid = st != S_IDLE;
  assign mem_we    = st == S_WB;
  assign mem_addr  = (st == S_WB) ? {tag_q[m_idx], m_idx, cnt_q} : {m_tag, m_idx, fill_off};
  assign mem_wdata = data_q[{m_idx, cnt_q}];

  always_ff @(posedge clk) begin
    if (fill_wr) data_q[{m_idx, fill_off}] <= mem_rdata;
    else if (hit_wr) data_q[{c_idx, c_off}] <= cpu_wdata;
    if (fill_wr && last) tag_q[m_idx] <= m_tag;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      valid_q   <= '0;
      dirty_q   <= '0;
      got_q     <= '0;
      miss_q    <= '0;
      miss_we_q <= 1'b0;
      cnt_q     <= '0;
    end else begin
      case (st)
        S_IDLE: begin
          if (hit_wr) dirty_q[c_idx] <= 1'b1;
          if (cpu_req && !tag_hit) begin
            miss_q    <= cpu_addr;
            miss_we_q <= cpu_we;
            cnt_q     <= '0;
            got_q     <= '0;
            st        <= (valid_q[c_idx] && dirty_q[c_idx]) ? S_WB : S_FILL;
          end
        end
        S_WB: if (beat) begin
          cnt_q <= cnt_q + OFF_W'(1);
          if (last) st <= S_FILL;
        end
        S_FILL: if (beat) begin
          got_q[fill_off] <= 1'b1;
          cnt_q <= cnt_q + OFF_W'(1);
          if (last) begin
            valid_q[m_idx] <= 1'b1;
            dirty_q[m_idx] <= 1'b0;
            st <= S_IDLE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dm_cwf_cache_chk.sv
`timescale 1ns/1ps
module dm_cwf_cache_chk #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 32,
  parameter int WORDS  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_we,
  input logic              cpu_ready,
  input logic              mem_valid,
  input logic              mem_ready,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_wdata
);
  localparam int OFF_W = $clog2(WORDS);

  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_we) && $stable(mem_addr) && $stable(mem_wdata));

  p_wrap_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_we && $past(mem_valid && mem_ready && !mem_we) |->
      mem_addr[ADDR_W-1:OFF_W] == $past(mem_addr[ADDR_W-1:OFF_W]) &&
      mem_addr[OFF_W-1:0] == $past(mem_addr[OFF_W-1:0]) + OFF_W'(1));

  p_wb_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_valid) && mem_we |-> mem_addr[OFF_W-1:0] == '0);

  p_wb_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && mem_we && $past(mem_valid && mem_ready && mem_we) |->
      mem_addr[OFF_W-1:0] == $past(mem_addr[OFF_W-1:0]) + OFF_W'(1));

  p_wb_then_fill_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && mem_ready && mem_we && mem_addr[OFF_W-1:0] == {OFF_W{1'b1}} |=> mem_valid && !mem_we);

  p_store_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready && cpu_we |-> !mem_valid);

  p_fill_reads_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready && mem_valid |-> !mem_we && !cpu_we);

  p_reset_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !mem_valid);
endmodule

bind dm_cwf_cache dm_cwf_cache_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WORDS(WORDS)) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_we(cpu_we), .cpu_ready(cpu_ready),
  .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_we(mem_we),
  .mem_addr(mem_addr), .mem_wdata(mem_wdata));

// File: tb/dm_cwf_cache_tb_top.sv
`timescale 1ns/1ps
module dm_cwf_cache_tb_top;
  localparam int ADDR_W = 10, DATA_W = 32, LINES = 16, WORDS = 4;
  localparam int MEMW = 1 << ADDR_W;

  logic clk = 0, rst_n = 0;
  logic cpu_req = 0, cpu_we = 0;
  logic [ADDR_W-1:0] cpu_addr = '0;
  logic [DATA_W-1:0] cpu_wdata = '0;
  logic cpu_ready, mem_valid, mem_we;
  logic [DATA_W-1:0] cpu_rdata, mem_wdata, mem_rdata;
  logic [ADDR_W-1:0] mem_addr;
  logic mem_ready = 0;

  logic [DATA_W-1:0] mem  [MEMW];
  logic [DATA_W-1:0] gold [MEMW];
  assign mem_rdata = mem[mem_addr];

  always #2.5 clk = ~clk;

  dm_cwf_cache #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINES(LINES), .WORDS(WORDS)) dut_i (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
    .mem_valid(mem_valid), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ready(mem_ready), .mem_rdata(mem_rdata));

  int n_cmp = 0, n_bad = 0, tick = 0, wbeats = 0;
  bit slow = 0, done = 0;

  int m_tag [LINES];
  bit m_valid [LINES], m_dirty [LINES];
  logic [DATA_W-1:0] m_data [LINES][WORDS];
  bit q_we [$];
  int q_addr [$];
  logic [DATA_W-1:0] q_data [$];

  bit last_hit, last_busy;
  int last_cyc;

  task automatic chk(bit ok, string m, longint act, longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", m, act, exp);
    end
  endtask

  always @(negedge clk) begin
    tick++;
    mem_ready = slow ? (tick % 3 != 0) : 1'b1;
    #1;
    if (rst_n && mem_valid && mem_ready) begin
      if (mem_we) wbeats++;
      if (q_we.size() == 0) chk(0, "R9 unexpected memory beat", mem_addr, 0);
      else begin
        chk(mem_we == q_we[0] && mem_addr == q_addr[0] && (!mem_we || mem_wdata == q_data[0]),
            mem_we ? (slow ? "R8 R11 write-back beat" : "R8 write-back beat")
                   : (slow ? "R4 R11 refill beat" : "R4 refill beat"),
            mem_addr, q_addr[0]);
        void'(q_we.pop_front()); void'(q_addr.pop_front()); void'(q_data.pop_front());
      end
      if (mem_we) mem[mem_addr] = mem_wdata;
    end
  end

  function automatic void predict(bit we, int a, logic [DATA_W-1:0] wd, output bit hit, output logic [DATA_W-1:0] rd);
    int idx = (a / WORDS) % LINES;
    int off = a % WORDS;
    int tg  = a / (WORDS * LINES);
    hit = m_valid[idx] && m_tag[idx] == tg;
    if (!hit) begin
      if (m_valid[idx] && m_dirty[idx])
        for (int w = 0; w < WORDS; w++) begin
          int wa = (m_tag[idx] * LINES + idx) * WORDS + w;
          q_we.push_back(1); q_addr.push_back(wa); q_data.push_back(m_data[idx][w]);
          gold[wa] = m_data[idx][w];
        end
      for (int k = 0; k < WORDS; k++) begin
        int fo = (off + k) % WORDS;
        int fa = (tg * LINES + idx) * WORDS + fo;
        q_we.push_back(0); q_addr.push_back(fa); q_data.push_back('0);
        m_data[idx][fo] = gold[fa];
      end
      m_valid[idx] = 1; m_tag[idx] = tg; m_dirty[idx] = 0;
    end
    if (we) begin m_data[idx][off] = wd; m_dirty[idx] = 1; rd = wd; end
    else rd = m_data[idx][off];
  endfunction

  task automatic op(bit we, int a, logic [DATA_W-1:0] wd, bit wait_idle, string rq);
    bit h, crit;
    logic [DATA_W-1:0] e, rd;
    int cyc;
    if (wait_idle) while (mem_valid || q_we.size() != 0) @(negedge clk);
    predict(we, a, wd, h, e);
    @(negedge clk);
    cpu_req = 1; cpu_we = we; cpu_addr = ADDR_W'(a); cpu_wdata = wd; cyc = 0;
    forever begin
      #2;
      if (cpu_ready || cyc > 2000) break;
      @(negedge clk);
      cyc++;
    end
    rd = cpu_rdata;
    crit = mem_valid && mem_ready && !mem_we && mem_addr == ADDR_W'(a);
    last_busy = mem_valid;
    @(posedge clk);
    #1 cpu_req = 0;
    if (!we) chk(rd === e, {rq, " read data"}, rd, e);
    if (wait_idle) chk(h ? cyc == 0 : cyc > 0, {rq, " hit/miss latency"}, cyc, h ? 0 : 1);
    if (wait_idle && !h && !we) chk(crit, "R5 read miss completes on critical beat", crit, 1);
    last_hit = h; last_cyc = cyc;
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_bad++; n_cmp++;
      $display("FAIL watchdog expired actual=hung expected=finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int seq [9] = '{0, 16, 32, 0, 16, 32, 64, 64, 0};
    bit exp_hit [9] = '{0, 0, 0, 1, 1, 1, 0, 1, 0};
    int misses = 0, wb0;
    logic [DATA_W-1:0] orig;
    for (int i = 0; i < MEMW; i++) begin
      mem[i] = 32'hA500_0000 ^ (i * 32'h0001_0003);
      gold[i] = mem[i];
    end
    for (int i = 0; i < LINES; i++) begin m_valid[i] = 0; m_dirty[i] = 0; m_tag[i] = 0; end
    repeat (3) @(negedge clk);
    #1;
    chk(mem_valid == 0, "R2 no memory beat in reset", mem_valid, 0);
    chk(cpu_ready == 0, "R2 no completion in reset", cpu_ready, 0);
    @(negedge clk) rst_n = 1;

    // R3 scaled conflict sequence; first access after reset also covers R2
    for (int i = 0; i < 9; i++) begin
      op(0, seq[i], '0, 1, "R3");
      if (i == 0) chk(last_cyc > 0, "R2 first access misses", last_cyc, 1);
      chk(last_hit == exp_hit[i], "R3 expected hit pattern", last_hit, exp_hit[i]);
      if (last_cyc > 0) misses++;
    end
    chk(misses == 5, "R3 miss count", misses, 5);
    chk(wbeats == 0, "R9 clean evictions write nothing", wbeats, 0);

    // R4/R5 wrap from a middle offset
    op(0, 'h105, '0, 1, "R5");

    // R6 in-fill behaviour, always-ready memory
    op(0, 'h20A, '0, 1, "R5");
    op(0, 'h20A, '0, 0, "R6");
    chk(last_cyc == 0 && last_busy, "R6 arrived word hits during fill", last_cyc, 0);
    op(0, 'h20B, '0, 0, "R6");
    chk(last_cyc == 0 && last_busy, "R6 second arrived word hits during fill", last_cyc, 0);
    op(0, 'h209, '0, 0, "R6");
    chk(last_cyc > 0, "R6 unarrived word waits", last_cyc, 1);
    op(0, 'h30C, '0, 1, "R5");
    op(1, 'h30D, 32'hDEAD_0001, 0, "R6");
    chk(last_cyc > 0, "R6 store waits for fill", last_cyc, 1);

    // R7 store hit
    op(0, 'h30E, '0, 1, "R1");
    orig = mem['h30E];
    wb0 = wbeats;
    op(1, 'h30E, 32'hC0DE_0002, 1, "R7");
    repeat (4) @(negedge clk);
    chk(wbeats == wb0 && q_we.size() == 0, "R7 store hit makes no memory beat", wbeats, wb0);
    chk(mem['h30E] == orig, "R7 memory untouched", mem['h30E], orig);
    op(0, 'h30E, '0, 1, "R7");

    // R8 dirty eviction under a stalling memory
    slow = 1;
    op(0, 'h34C, '0, 1, "R8");
    while (mem_valid || q_we.size() != 0) @(negedge clk);
    chk(wbeats - wb0 == WORDS, "R8 whole line written back", wbeats - wb0, WORDS);
    chk(mem['h30E] == 32'hC0DE_0002, "R8 store data reached memory", mem['h30E], 32'hC0DE_0002);
    chk(mem['h30D] == 32'hDEAD_0001, "R8 in-fill store reached memory", mem['h30D], 32'hDEAD_0001);

    // R10 write miss allocates
    slow = 0;
    wb0 = wbeats;
    op(1, 'h0A1, 32'h5EED_0003, 1, "R10");
    op(0, 'h0A1, '0, 1, "R10");
    op(0, 'h0A2, '0, 1, "R10");
    chk(wbeats == wb0, "R9 write miss to clean line writes nothing", wbeats, wb0);
    op(0, 'h021, '0, 1, "R10");
    while (mem_valid || q_we.size() != 0) @(negedge clk);
    chk(mem['h0A1] == 32'h5EED_0003, "R10 allocated line was dirty", mem['h0A1], 32'h5EED_0003);

    // R1 mixed traffic
    slow = 1;
    for (int i = 0; i < 300; i++)
      op(bit'($urandom_range(0, 2) == 0), int'($urandom_range(0, 511)), $urandom, 1, "R1");
    while (mem_valid || q_we.size() != 0) @(negedge clk);
    chk(q_we.size() == 0, "R4 R8 all expected beats seen", q_we.size(), 0);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule